// File: doc/BRIEF.md
# Relocatable Peripheral Window Decoder

This block decodes byte accesses into a 64 KiB register aperture and routes each one to one of three targets. The first 256-byte page always goes to the system control registers. The second page is a small configuration space that the block implements itself. Any other page can reach a peripheral register window, but only after software has placed and opened that window.

The configuration space holds two things. A command byte carries the window enable. A 32-bit base register, written one byte lane at a time, sets the page where the window appears. Each target receives a select, an 8-bit offset inside its page, and the write strobe and data. The block then returns the read data of the selected target on a single registered bus.

The decode is a short pipeline. Selects, offset and strobes appear one clock after the access is presented. The read data appears one clock after that. Configuration writes take effect at the edge that decodes them, so the very next access already sees the new window.

Top module: `pwin_decoder`

## Requirements
- R1: An access (read or write strobe high) whose address bits 15:8 are 0 raises `sys_sel` in the following cycle, with `loc_off` equal to address bits 7:0 and `loc_wdata` carrying the write data.
- R2: An access whose address bits 15:8 equal 1 raises `cfg_sel` in the following cycle and is served by the internal configuration space.
- R3: The command byte sits at configuration offset 0x04. Write-data bit 1 sets the window enable and all other written bits are ignored. It reads back 0x02 when enabled and 0x00 when disabled.
- R4: The 32-bit base register occupies configuration offsets 0x10, 0x11, 0x12 and 0x13, holding bits 7:0, 15:8, 23:16 and 31:24 (little-endian). Each offset reads back its own lane.
- R5: An access to any other page raises `win_sel` when the enable is set and address bits 15:8 equal base bits 15:8. Base bits 7:0 and 31:16 take no part in the comparison.
- R6: While the enable is clear, no access to a page other than 0 or 1 raises any select, and a read there returns 0.
- R7: Pages 0 and 1 keep priority over the window. A base whose bits 15:8 are 0 or 1 never raises `win_sel`.
- R8: An access that matches no target raises no select and writes nothing, and a read of it returns 0. Configuration offsets other than 0x04 and 0x10 to 0x13 read 0 and ignore writes.
- R9: At most one of `sys_sel`, `cfg_sel` and `win_sel` is high in any cycle, and all three are low in any cycle that follows a cycle with no access.
- R10: `bus_rdata` shows the read result two clock edges after the read is presented, and is 0 in every cycle whose previous decode stage held no read.
- R11: A synchronous active-high reset clears the enable, the base register and all outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 16 | Byte address within the aperture |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access (wins over a read) |
| bus_wdata | input | 8 | Write data |
| sys_rdata | input | 8 | Read data returned by the system control registers |
| win_rdata | input | 8 | Read data returned by the peripheral window |
| sys_sel | output | 1 | System control registers selected |
| cfg_sel | output | 1 | Configuration space selected |
| win_sel | output | 1 | Peripheral window selected |
| loc_off | output | 8 | Byte offset within the selected page |
| loc_rd | output | 1 | Read strobe to the selected target |
| loc_wr | output | 1 | Write strobe to the selected target |
| loc_wdata | output | 8 | Write data to the selected target |
| bus_rdata | output | 8 | Registered read data |

## Verification
The decode is tried with several kinds of address:
- an address in each fixed page;
- an address in the programmed window page, and one in the neighbouring page;
- the same window address with the enable cleared;
- a base that points at a fixed page.

Each of these separates a different fault: a wrong page compare, a missing enable gate, or a broken priority. The configuration space is written with stray bits in the command byte and distinct values in every base lane. Reading those values back shows whether lane order and bit masking are right. It also shows that the base bytes outside the compare do not change the match.

// File: rtl/pwin_pkg.sv
package pwin_pkg;
  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_SYS  = 2'd1,
    TGT_CFG  = 2'd2,
    TGT_WIN  = 2'd3
  } tgt_e;
endpackage

// File: rtl/pwin_addr_match.sv
module pwin_addr_match
  import pwin_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int OFS_W  = 8
) (
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    access,
  input  logic                    win_en,
  input  logic [ADDR_W-OFS_W-1:0] win_page,
  output tgt_e                    tgt
);
  localparam int PAGE_W = ADDR_W - OFS_W;
  localparam logic [PAGE_W-1:0] SYS_PAGE = PAGE_W'(0);
  localparam logic [PAGE_W-1:0] CFG_PAGE = PAGE_W'(1);

  logic [PAGE_W-1:0] page;
  assign page = addr[ADDR_W-1:OFS_W];

  always_comb begin
    tgt = TGT_NONE;
    if (access) begin
      if (page == SYS_PAGE)                      tgt = TGT_SYS;
      else if (page == CFG_PAGE)                 tgt = TGT_CFG;
      else if (win_en && (page == win_page))     tgt = TGT_WIN;
    end
  end
endmodule

// File: rtl/pwin_cfg_space.sv
module pwin_cfg_space #(
  parameter int OFS_W    = 8,
  parameter int DATA_W   = 8,
  parameter int BASE_W   = 32,
  parameter int CMD_OFS  = 4,
  parameter int BASE_OFS = 16,
  parameter int EN_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [OFS_W-1:0]  off,
  input  logic [DATA_W-1:0] wdata,
  output logic              win_en,
  output logic [BASE_W-1:0] base,
  output logic [DATA_W-1:0] rdata
);
  localparam int LANES = BASE_W / DATA_W;
  localparam logic [OFS_W-1:0] CMD_A = OFS_W'(CMD_OFS);

  logic [DATA_W-1:0] lane_rd [LANES];
  logic [LANES-1:0]  lane_hit;

  always_ff @(posedge clk) begin
    if (rst)                          win_en <= 1'b0;
    else if (wr_en && off == CMD_A)   win_en <= wdata[EN_BIT];
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    localparam logic [OFS_W-1:0] LANE_A = OFS_W'(BASE_OFS + g);
    assign lane_hit[g] = (off == LANE_A);
    assign lane_rd[g]  = base[g*DATA_W +: DATA_W];
    always_ff @(posedge clk) begin
      if (rst)                      base[g*DATA_W +: DATA_W] <= '0;
      else if (wr_en && lane_hit[g]) base[g*DATA_W +: DATA_W] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    if (off == CMD_A) rdata[EN_BIT] = win_en;
    for (int i = 0; i < LANES; i++)
      if (lane_hit[i]) rdata = lane_rd[i];
  end

  // R3: enable follows the written bit
  a_r3_cmd_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && off == CMD_A) |=> (win_en == $past(wdata[EN_BIT])));
  // R4: lowest lane takes the written byte
  a_r4_lane_write: assert property (@(posedge clk) disable iff (rst)
    (wr_en && lane_hit[0]) |=> (base[DATA_W-1:0] == $past(wdata)));
  // R8: writes outside the map leave state alone
  a_r8_cfg_drop: assert property (@(posedge clk) disable iff (rst)
    (wr_en && off != CMD_A && lane_hit == '0) |=> ($stable(base) && $stable(win_en)));
endmodule

// File: rtl/pwin_rdata_mux.sv
module pwin_rdata_mux
  import pwin_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_q,
  input  tgt_e              tgt_q,
  input  logic [DATA_W-1:0] cfg_q,
  input  logic [DATA_W-1:0] sys_rdata,
  input  logic [DATA_W-1:0] win_rdata,
  output logic [DATA_W-1:0] bus_rdata
);
  always_ff @(posedge clk) begin
    if (rst || !rd_q) bus_rdata <= '0;
    else begin
      unique case (tgt_q)
        TGT_SYS: bus_rdata <= sys_rdata;
        TGT_CFG: bus_rdata <= cfg_q;
        TGT_WIN: bus_rdata <= win_rdata;
        default: bus_rdata <= '0;
      endcase
    end
  end

  // R10: no read in the decode stage gives zero
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !rd_q |=> (bus_rdata == '0));
  // R8: an unmatched read returns zero
  a_r8_none_zero: assert property (@(posedge clk) disable iff (rst)
    (rd_q && tgt_q == TGT_NONE) |=> (bus_rdata == '0));
endmodule

// File: rtl/pwin_decoder.sv
module pwin_decoder
  import pwin_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int OFS_W    = 8,
  parameter int DATA_W   = 8,
  parameter int BASE_W   = 32,
  parameter int CMD_OFS  = 4,
  parameter int BASE_OFS = 16,
  parameter int EN_BIT   = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] sys_rdata,
  input  logic [DATA_W-1:0] win_rdata,
  output logic              sys_sel,
  output logic              cfg_sel,
  output logic              win_sel,
  output logic [OFS_W-1:0]  loc_off,
  output logic              loc_rd,
  output logic              loc_wr,
  output logic [DATA_W-1:0] loc_wdata,
  output logic [DATA_W-1:0] bus_rdata
);
  localparam int PAGE_W = ADDR_W - OFS_W;

  logic              access, rd_eff, wr_eff;
  logic              win_en;
  logic [BASE_W-1:0] base;
  logic [DATA_W-1:0] cfg_rdata;
  tgt_e              tgt, tgt_q;
  logic              rd_q;
  logic [DATA_W-1:0] cfg_q;

  assign access = bus_rd | bus_wr;
  assign wr_eff = bus_wr;
  assign rd_eff = bus_rd & ~bus_wr;

  pwin_addr_match #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_match (
    .addr     (bus_addr),
    .access   (access),
    .win_en   (win_en),
    .win_page (base[ADDR_W-1:OFS_W]),
    .tgt      (tgt)
  );

  pwin_cfg_space #(
    .OFS_W(OFS_W), .DATA_W(DATA_W), .BASE_W(BASE_W),
    .CMD_OFS(CMD_OFS), .BASE_OFS(BASE_OFS), .EN_BIT(EN_BIT)
  ) u_cfg (
    .clk    (clk),
    .rst    (rst),
    .wr_en  (wr_eff && tgt == TGT_CFG),
    .off    (bus_addr[OFS_W-1:0]),
    .wdata  (bus_wdata),
    .win_en (win_en),
    .base   (base),
    .rdata  (cfg_rdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_q     <= TGT_NONE;
      rd_q      <= 1'b0;
      loc_off   <= '0;
      loc_wr    <= 1'b0;
      loc_wdata <= '0;
      cfg_q     <= '0;
    end else begin
      tgt_q     <= tgt;
      rd_q      <= rd_eff;
      loc_off   <= (tgt != TGT_NONE) ? bus_addr[OFS_W-1:0] : '0;
      loc_wr    <= wr_eff && (tgt != TGT_NONE);
      loc_wdata <= wr_eff ? bus_wdata : '0;
      cfg_q     <= cfg_rdata;
    end
  end

  assign sys_sel = (tgt_q == TGT_SYS);
  assign cfg_sel = (tgt_q == TGT_CFG);
  assign win_sel = (tgt_q == TGT_WIN);
  assign loc_rd  = rd_q && (tgt_q != TGT_NONE);

  pwin_rdata_mux #(.DATA_W(DATA_W)) u_rmux (
    .clk       (clk),
    .rst       (rst),
    .rd_q      (rd_q),
    .tgt_q     (tgt_q),
    .cfg_q     (cfg_q),
    .sys_rdata (sys_rdata),
    .win_rdata (win_rdata),
    .bus_rdata (bus_rdata)
  );

  // R9: selects are mutually exclusive
  a_r9_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0({sys_sel, cfg_sel, win_sel}));
  // R9: idle cycle gives no select next
  a_r9_idle: assert property (@(posedge clk) disable iff (rst)
    !access |=> !(sys_sel || cfg_sel || win_sel));
  // R1: page zero goes to system registers
  a_r1_sys_page: assert property (@(posedge clk) disable iff (rst)
    (access && bus_addr[ADDR_W-1:OFS_W] == PAGE_W'(0)) |=>
      (sys_sel && loc_off == $past(bus_addr[OFS_W-1:0])));
  // R2: page one goes to configuration space
  a_r2_cfg_page: assert property (@(posedge clk) disable iff (rst)
    (access && bus_addr[ADDR_W-1:OFS_W] == PAGE_W'(1)) |=> cfg_sel);
  // R6: closed window is never selected
  a_r6_closed: assert property (@(posedge clk) disable iff (rst)
    !win_en |=> !win_sel);
endmodule

// File: tb/pwin_decoder_bench.sv
module pwin_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  sys_rdata = 8'hA5, win_rdata = 8'h3C;
  logic        sys_sel, cfg_sel, win_sel, loc_rd, loc_wr;
  logic [7:0]  loc_off, loc_wdata, bus_rdata;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  pwin_decoder u_pwin_decoder (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .sys_rdata(sys_rdata), .win_rdata(win_rdata),
    .sys_sel(sys_sel), .cfg_sel(cfg_sel), .win_sel(win_sel), .loc_off(loc_off),
    .loc_rd(loc_rd), .loc_wr(loc_wr), .loc_wdata(loc_wdata), .bus_rdata(bus_rdata)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // One read: returns the selects {sys,cfg,win}, offset, and data
  task automatic do_read(input logic [15:0] a, output logic [2:0] sel,
                         output logic [7:0] off, output logic [7:0] d);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    sel = {sys_sel, cfg_sel, win_sel}; off = loc_off;
    bus_rd = 1'b0;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic do_write(input logic [15:0] a, input logic [7:0] v, output logic [2:0] sel);
    bus_addr = a; bus_wdata = v; bus_wr = 1'b1;
    @(negedge clk);
    sel = {sys_sel, cfg_sel, win_sel};
    bus_wr = 1'b0; bus_wdata = '0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [2:0] s; logic [7:0] o, d;
    check({sys_sel, cfg_sel, win_sel, loc_wr, loc_rd} == 0 && bus_rdata == 0, "R11 outputs", bus_rdata, 0);
    do_read(16'h0104, s, o, d);
    check(d == 8'h00, "R11 enable clear", d, 8'h00);
    do_read(16'h0111, s, o, d);
    check(d == 8'h00, "R11 base clear", d, 8'h00);
  endtask

  task automatic t_sys();
    logic [2:0] s; logic [7:0] o, d;
    do_read(16'h0042, s, o, d);
    check(s == 3'b100 && o == 8'h42, "R1 sys select", {s, o}, {3'b100, 8'h42});
    check(d == 8'hA5, "R10 sys data", d, 8'hA5);
    bus_addr = 16'h00FF; bus_wdata = 8'h5A; bus_wr = 1'b1;
    @(negedge clk);
    check(sys_sel && loc_wr && loc_wdata == 8'h5A && loc_off == 8'hFF, "R1 sys write", loc_wdata, 8'h5A);
    bus_wr = 1'b0;
    @(negedge clk);
    check({sys_sel, cfg_sel, win_sel} == 0 && bus_rdata == 0, "R9 R10 idle after write", bus_rdata, 0);
  endtask

  task automatic t_cfg();
    logic [2:0] s; logic [7:0] o, d;
    do_write(16'h0104, 8'hFD, s);
    check(s == 3'b010, "R2 cfg select", s, 3'b010);
    do_read(16'h0104, s, o, d);
    check(d == 8'h00, "R3 bit1 clear stays off", d, 8'h00);
    do_write(16'h0104, 8'h02, s);
    do_read(16'h0104, s, o, d);
    check(d == 8'h02, "R3 enabled reads 2", d, 8'h02);
    do_write(16'h0105, 8'h77, s);
    do_read(16'h0105, s, o, d);
    check(d == 8'h00, "R8 unused cfg offset", d, 8'h00);
  endtask

  task automatic t_base();
    logic [2:0] s; logic [7:0] o, d;
    logic [7:0] v [4] = '{8'h11, 8'h37, 8'hAB, 8'hCD};
    for (int i = 0; i < 4; i++) do_write(16'h0110 + 16'(i), v[i], s);
    for (int i = 0; i < 4; i++) begin
      do_read(16'h0110 + 16'(i), s, o, d);
      check(d == v[i], "R4 lane readback", d, v[i]);
    end
  endtask

  task automatic t_win();
    logic [2:0] s; logic [7:0] o, d;
    do_read(16'h3720, s, o, d);
    check(s == 3'b001 && o == 8'h20, "R5 window select", {s, o}, {3'b001, 8'h20});
    check(d == 8'h3C, "R5 window data", d, 8'h3C);
    do_read(16'h3820, s, o, d);
    check(s == 3'b000 && d == 8'h00, "R8 unmatched page", {s, d}, 0);
    do_write(16'h3820, 8'h99, s);
    check(s == 3'b000, "R8 unmatched write", s, 0);
  endtask

  task automatic t_disable();
    logic [2:0] s; logic [7:0] o, d;
    do_write(16'h0104, 8'h00, s);
    do_read(16'h3720, s, o, d);
    check(s == 3'b000 && d == 8'h00, "R6 closed window", {s, d}, 0);
    do_write(16'h3720, 8'h12, s);
    check(s == 3'b000, "R6 closed write", s, 0);
  endtask

  task automatic t_shadow();
    logic [2:0] s; logic [7:0] o, d;
    do_write(16'h0104, 8'h02, s);
    do_write(16'h0111, 8'h01, s);
    do_read(16'h0110, s, o, d);
    check(s == 3'b010 && d == 8'h11, "R7 cfg beats window", {s, d}, {3'b010, 8'h11});
    do_write(16'h0111, 8'h00, s);
    do_read(16'h0005, s, o, d);
    check(s == 3'b100 && d == 8'hA5, "R7 sys beats window", {s, d}, {3'b100, 8'hA5});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_sys();
    t_cfg();
    t_base();
    t_win();
    t_disable();
    t_shadow();
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule